// File: doc/BRIEF.md
# Routed level-interrupt controller

This block gathers nine external interrupt inputs and presents them on three interrupt request lines toward a host interrupt controller. Each input is synchronised into the block's clock domain and then corrected for polarity, so every source can be declared active-high or active-low. Sensing is by level only. A source reaches a request line when software enables it in that line's register. One source can be enabled on any subset of the lines.

Each line has one 32-bit register. Its low half holds the enables for that line. Its upper half holds the pending flags for that line, and a flag is acknowledged by writing a one to it. Writing zeros to the pending field leaves the flags as they are, so software can rewrite the enables freely. A request line stays high while any pending flag in its register is set. Register access uses a simple word bus with an address, a write strobe, write data and combinational read data.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset, every register reads 0. The polarity register then marks all sources active-low. All three request lines are low.
- R2: The polarity register is at byte address 0x0. Bit n (n = 0..8) holds the polarity of source n. Bits 31:9 read 0 and ignore writes.
- R3: Line k (k = 0..2) has its register at byte address 0x4 + 4*k. Bits 8:0 are the enables and read back what was written. Bits 15:9 and 31:25 read 0 and ignore writes.
- R4: Pending bit 16+n of line k is set on a clock edge when source n is active and enable n of line k is set. An input change first shows in the pending bit 3 clock edges later: two synchroniser stages, then the pending register.
- R5: When polarity bit n is 1, source n is active while its pin is high. When polarity bit n is 0, source n is active while its pin is low.
- R6: Writing 1 to pending bit 16+n clears that bit. Writing 0 leaves it unchanged. If source n is still active and enabled on that line in the same cycle, the bit is set again and the clear has no effect.
- R7: A pending bit stays set after its source goes inactive, until software clears it.
- R8: Request line k is high exactly while at least one pending bit of line k's register is set.
- R9: A source sets pending bits only in the lines that enable it. Lines that do not enable it keep that bit at 0.
- R10: Writing 0x01FF0000 to a line register clears all of its pending bits and disables all sources, provided no source is active and enabled at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_in | input | 9 | Asynchronous interrupt source pins |
| irq_out | output | 3 | Request lines, active high |

## Verification
The bench checks the three-edge latency from pin to pending bit. A design with one synchroniser stage too few or too many would raise the line one cycle early or one cycle late.

It also checks an acknowledge written while the source is still active. A design that lets the clear win would drop a level that is still asserted and lose the interrupt.

Other directed cases cover:
- a write with zeros in the pending field, which a design that overwrites the flags would wipe;
- polarity inversion;
- a source enabled on a single line, which a design with crossed routing would raise on the wrong line;
- the reserved bits, which a design that stores them would read back as nonzero.

Long random runs against a bench model cover the remaining interleavings of writes and pin changes.

// File: rtl/lvl_irq_router_pkg.sv
package lvl_irq_router_pkg;
  localparam int unsigned SRC_COUNT  = 9;
  localparam int unsigned LINE_COUNT = 3;
  localparam int unsigned PEND_LSB   = 16;
  localparam int unsigned WORD_BITS  = 32;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/lvl_irq_rst_sync.sv
module lvl_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/lvl_irq_src_sync.sv
module lvl_irq_src_sync #(
  parameter int unsigned WIDTH = 9,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = pin_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/lvl_irq_line.sv
module lvl_irq_line #(
  parameter int unsigned NSRC     = 9,
  parameter int unsigned PEND_POS = 16,
  parameter int unsigned DW       = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] act_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] pend_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] pend_q, pend_d;
  logic [NSRC-1:0] clr_mask;
  logic [NSRC-1:0] hit;

  always_comb begin
    clr_mask = wr_i ? wdata_i[PEND_POS +: NSRC] : '0;
    hit      = act_i & en_q;
    en_d     = wdata_i[NSRC-1:0];
    pend_d   = (pend_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;

  AST_PEND_SETS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(act_i & en_q)) == $past(act_i & en_q))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((pend_q & $past(wdata_i[PEND_POS +: NSRC] & ~(act_i & en_q))) == '0)); // R6
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R7
  AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(act_i & en_q) != '0)); // R8
endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_router_pkg::*;
#(
  parameter int unsigned NSRC   = SRC_COUNT,
  parameter int unsigned NLINE  = LINE_COUNT,
  parameter int unsigned ADDR_W = $clog2((NLINE + 1) * 4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  input  logic [NSRC-1:0]      src_in,
  output logic [NLINE-1:0]     irq_out
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              rst_q_n;
  logic [NSRC-1:0]   src_sync;
  logic [NSRC-1:0]   active;
  logic [NSRC-1:0]   pol_q, pol_d;
  logic              pol_we;
  logic [IDX_W-1:0]  word_idx;
  logic [NSRC-1:0]   line_en   [NLINE];
  logic [NSRC-1:0]   line_pend [NLINE];

  lvl_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  lvl_irq_src_sync #(.WIDTH(NSRC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .pin_i  (src_in),
    .sync_o (src_sync)
  );

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign active   = ~(src_sync ^ pol_q);
  assign pol_we   = bus_we && (word_idx == '0);

  always_comb begin
    pol_d = bus_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pol_q <= '0;
    end else if (pol_we) begin
      pol_q <= pol_d;
    end
  end

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    logic line_we;
    assign line_we = bus_we && (word_idx == IDX_W'(k + 1));
    lvl_irq_line #(.NSRC(NSRC), .PEND_POS(PEND_LSB), .DW(WORD_BITS)) u_line (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .wr_i    (line_we),
      .wdata_i (bus_wdata),
      .act_i   (active),
      .en_o    (line_en[k]),
      .pend_o  (line_pend[k]),
      .irq_o   (irq_out[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (word_idx == '0) begin
      bus_rdata[NSRC-1:0] = pol_q;
    end else begin
      for (int k = 0; k < NLINE; k++) begin
        if (word_idx == IDX_W'(k + 1)) begin
          bus_rdata[NSRC-1:0]           = line_en[k];
          bus_rdata[PEND_LSB +: NSRC]   = line_pend[k];
        end
      end
    end
  end

  AST_POL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_q_n)
    pol_we |=> (pol_q == $past(bus_wdata[NSRC-1:0]))); // R2
endmodule

// File: tb/lvl_irq_router_test.sv
module lvl_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [8:0]  src_in;
  logic [2:0]  irq_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [8:0] m_pol, m_s1, m_s2;
  logic [8:0] m_en [3];
  logic [8:0] m_st [3];

  always #10 clk = ~clk;

  lvl_irq_router uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_in    (src_in),
    .irq_out   (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    logic [31:0] r;
    r = '0;
    if (a[3:2] == 2'd0) r[8:0] = m_pol;
    else begin
      r[8:0]   = m_en[a[3:2]-1];
      r[24:16] = m_st[a[3:2]-1];
    end
    return r;
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = |m_st[k];
    return r;
  endfunction

  task automatic m_update(input logic [8:0] s, input logic w, input logic [3:0] a, input logic [31:0] d);
    logic [8:0] act;
    act = ~(m_s2 ^ m_pol);
    for (int k = 0; k < 3; k++) begin
      logic hitw;
      hitw = w && (a[3:2] == 2'(k + 1));
      m_st[k] = (m_st[k] & ~(hitw ? d[24:16] : 9'h0)) | (act & m_en[k]);
      if (hitw) m_en[k] = d[8:0];
    end
    if (w && a[3:2] == 2'd0) m_pol = d[8:0];
    m_s2 = m_s1;
    m_s1 = s;
  endtask

  task automatic step(input logic [8:0] s, input logic w, input logic [3:0] a, input logic [31:0] d);
    src_in = s; bus_we = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    m_update(s, w, a, d);
    @(negedge clk);
    chk("R8 irq vs model", {29'b0, irq_out}, {29'b0, m_irq()});
    chk("R4 read vs model", bus_rdata, m_read(a));
  endtask

  task automatic rd(input logic [8:0] s, input logic [3:0] a, input logic [31:0] exp, input string tag);
    step(s, 1'b0, a, 32'h0);
    chk(tag, bus_rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; src_in = '0;
    m_pol = '0; m_s1 = '0; m_s2 = '0;
    for (int k = 0; k < 3; k++) begin m_en[k] = '0; m_st[k] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {29'b0, irq_out}, 32'h0);
    for (int a = 0; a < 16; a += 4) rd(9'h0, 4'(a), 32'h0, "R1 reg after reset");

    // R4 latency of three edges, pol high
    step(9'h0, 1'b1, 4'h0, 32'h0000_01FF);
    step(9'h0, 1'b1, 4'h4, 32'h0000_0008);
    step(9'h008, 1'b0, 4'h4, 32'h0);
    chk("R4 edge1 irq low", {29'b0, irq_out}, 32'h0);
    step(9'h008, 1'b0, 4'h4, 32'h0);
    chk("R4 edge2 irq low", {29'b0, irq_out}, 32'h0);
    step(9'h008, 1'b0, 4'h4, 32'h0);
    chk("R4 edge3 irq high", {29'b0, irq_out}, 32'h1);
    chk("R4 pending read", bus_rdata, 32'h0008_0008);

    // R7 pending held after source drops
    repeat (4) step(9'h0, 1'b0, 4'h4, 32'h0);
    chk("R7 held irq", {29'b0, irq_out}, 32'h1);
    chk("R7 held read", bus_rdata, 32'h0008_0008);

    // R6 zero write keeps, one write clears, active level overrides
    step(9'h0, 1'b1, 4'h4, 32'h0000_0008);
    rd(9'h0, 4'h4, 32'h0008_0008, "R6 zero keeps pending");
    step(9'h0, 1'b1, 4'h4, 32'h0008_0008);
    chk("R6 clear read", bus_rdata, 32'h0000_0008);
    chk("R8 line low after clear", {29'b0, irq_out}, 32'h0);
    repeat (3) step(9'h008, 1'b0, 4'h4, 32'h0);
    step(9'h008, 1'b1, 4'h4, 32'h0008_0008);
    chk("R6 active overrides clear", bus_rdata, 32'h0008_0008);

    // R5 active-low polarity for source 3
    step(9'h0, 1'b1, 4'h0, 32'h0000_01F7);
    repeat (3) step(9'h0, 1'b0, 4'h4, 32'h0);
    step(9'h0, 1'b1, 4'h4, 32'h0008_0008);
    chk("R5 low pin is active", bus_rdata, 32'h0008_0008);
    repeat (3) step(9'h008, 1'b0, 4'h4, 32'h0);
    step(9'h008, 1'b1, 4'h4, 32'h0008_0008);
    chk("R5 high pin inactive", bus_rdata, 32'h0000_0008);
    chk("R5 line low", {29'b0, irq_out}, 32'h0);

    // R9 routing to line 2 only
    step(9'h008, 1'b1, 4'hC, 32'h0000_0020);
    repeat (3) step(9'h028, 1'b0, 4'hC, 32'h0);
    chk("R9 only line 2", {29'b0, irq_out}, 32'h4);
    rd(9'h028, 4'h4, 32'h0000_0008, "R9 line 0 untouched");
    rd(9'h028, 4'h8, 32'h0000_0000, "R9 line 1 untouched");
    rd(9'h028, 4'hC, 32'h0020_0020, "R9 line 2 pending");

    // R2 / R3 reserved bits
    step(9'h028, 1'b1, 4'h0, 32'hFFFF_FFFF);
    chk("R2 polarity readback", bus_rdata, 32'h0000_01FF);
    step(9'h028, 1'b1, 4'h8, 32'hFE00_FFFF);
    chk("R3 enable readback", bus_rdata, 32'h0000_01FF);
    rd(9'h028, 4'h8, 32'h0028_01FF, "R3 pending after enable");

    // R10 init value on every line
    repeat (3) step(9'h0, 1'b0, 4'h0, 32'h0);
    for (int a = 4; a < 16; a += 4) step(9'h0, 1'b1, 4'(a), 32'h01FF_0000);
    for (int a = 4; a < 16; a += 4) rd(9'h0, 4'(a), 32'h0, "R10 line cleared");
    chk("R10 lines low", {29'b0, irq_out}, 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [8:0]  s;
      logic        w;
      logic [3:0]  a;
      logic [31:0] d;
      s = 9'($urandom);
      w = ($urandom % 4) == 0;
      a = 4'(($urandom % 4) * 4);
      d = $urandom;
      if (($urandom % 3) == 0) d = d & 32'h0000_FFFF;
      step(s, w, a, d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule